// File: doc/BRIEF.md
# Entropy-Driven Window and Mode Controller

This controller steers a jitter-based random source from a one-bit verdict on entropy quality. Each time the sample strobe is high at a clock edge, the controller reads the verdict and acts on it. A good verdict shortens the observation window by one step. A poor verdict lengthens it by one step. The window is held between a lower and an upper bound.

When the window already sits at its upper bound and the verdict is still poor, the controller stops stretching time and escalates structure instead. It raises the oscillator mode, which selects a shorter ring and so a faster oscillation. The mode stops at its top value. A one-hot stage-select vector is registered together with the mode, so that a ring multiplexer can use it directly.

Initial length, step, minimum and maximum are parameters. Their defaults are 30, 5, 20 and 60 on a 6-bit window. When the span and the starting offset are whole multiples of the step, a cheaper datapath without clamping is generated.

Top module: `entropy_adapt_ctrl`

## Requirements
- R1: An active-low reset `rst_n` acts asynchronously. At once, without waiting for a clock edge, it sets the window to the initial value (30 by default), the mode to 0 and the stage select to 3'b100.
- R2: While `sample_stb` is low, the window, mode and stage select hold their values, whatever `ent_good` does.
- R3: A strobe with `ent_good`=1 lowers the window by the step. If that would take it below the minimum, the window becomes the minimum.
- R4: A strobe with `ent_good`=1 while the window equals the minimum leaves window and mode unchanged.
- R5: A strobe with `ent_good`=0 while the window is below the maximum raises the window by the step. If that would pass the maximum, the window becomes the maximum. The mode does not change.
- R6: A strobe with `ent_good`=0 while the window equals the maximum increments the mode by one and leaves the window at the maximum.
- R7: The mode saturates at 3. A further escalation leaves it at 3 and never wraps to 0.
- R8: Exactly one bit of `stage_sel` is set. Bit 2 (7-stage ring) is set for mode 0. Bit 1 (5-stage ring) is set for mode 1. Bit 0 (3-stage ring) is set for modes 2 and 3, that is, it equals mode bit 1.
- R9: All outputs are registered. The effect of a strobe appears right after the clock edge at which the strobe is sampled, and not before.
- R10: A good verdict never lowers the mode. The mode changes only through R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe marking a valid entropy verdict |
| ent_good | input | 1 | Entropy verdict, 1 = sufficient |
| win_len | output | 6 | Current observation window length |
| osc_mode | output | 2 | Oscillator configuration code, 0..3 |
| stage_sel | output | 3 | One-hot ring-length select: [2]=7, [1]=5, [0]=3 stages |

## Verification
A corrupted window register shows on `win_len` in the cycle right after the next strobe. It shows as a step of the wrong size, a value outside the bounds, or a value that failed to clamp. A wrong at-bound decision shows up as a mode change while the window is below its maximum, or as a window that moves while the mode should escalate. Both are visible one edge after the offending strobe. A mode and select register that drift apart break the one-hot relation on `stage_sel` in the same cycle the mode moves. The strobe sequences used are short enough that every bound, and the mode ceiling, are reached within a few dozen cycles.

// File: rtl/entadp_pkg.sv
package entadp_pkg;

   localparam int SEL_W     = 3;
   localparam int SEL_LONG  = 2;
   localparam int SEL_MID   = 1;
   localparam int SEL_SHORT = 0;

   typedef enum logic [1:0] {
      ACT_HOLD     = 2'd0,
      ACT_SHRINK   = 2'd1,
      ACT_GROW     = 2'd2,
      ACT_ESCALATE = 2'd3
   } adapt_act_e;

   // Ring-length select from a 2-bit mode code
   function automatic logic [SEL_W-1:0] stage_decode(input logic [1:0] m);
      logic [SEL_W-1:0] s;
      s[SEL_LONG]  = ~(m[1] | m[0]);
      s[SEL_MID]   = ~(m[1] | ~m[0]);
      s[SEL_SHORT] = m[1];
      return s;
   endfunction

endpackage

// File: rtl/adapt_decider.sv
module adapt_decider
   import entadp_pkg::*;
(
   input  logic       sample_stb,
   input  logic       ent_good,
   input  logic       at_min,
   input  logic       at_max,
   output adapt_act_e act
);

   always_comb begin
      act = ACT_HOLD;
      if (sample_stb) begin
         if (ent_good) begin
            act = at_min ? ACT_HOLD : ACT_SHRINK;
         end else begin
            act = at_max ? ACT_ESCALATE : ACT_GROW;
         end
      end
   end

endmodule

// File: rtl/win_stepper.sv
module win_stepper
   import entadp_pkg::*;
#(
   parameter int WIN_W    = 6,
   parameter int WIN_INIT = 30,
   parameter int WIN_STEP = 5,
   parameter int WIN_MIN  = 20,
   parameter int WIN_MAX  = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  adapt_act_e       act,
   output logic [WIN_W-1:0] win_q,
   output logic             at_min,
   output logic             at_max
);

   localparam int EXT_W = WIN_W + 1;
   localparam logic [WIN_W-1:0] INIT_W = WIN_W'(WIN_INIT);
   localparam logic [WIN_W-1:0] STEP_W = WIN_W'(WIN_STEP);
   localparam logic [WIN_W-1:0] MIN_W  = WIN_W'(WIN_MIN);
   localparam logic [WIN_W-1:0] MAX_W  = WIN_W'(WIN_MAX);
   localparam logic [EXT_W-1:0] STEP_X = EXT_W'(WIN_STEP);
   localparam logic [EXT_W-1:0] MAX_X  = EXT_W'(WIN_MAX);
   localparam logic [EXT_W-1:0] FLOOR_X = EXT_W'(WIN_MIN + WIN_STEP);
   localparam bit ON_GRID = ((WIN_MAX - WIN_MIN) % WIN_STEP == 0) &&
                            ((WIN_INIT - WIN_MIN) % WIN_STEP == 0);

   logic [WIN_W-1:0] win_up;
   logic [WIN_W-1:0] win_dn;
   logic [WIN_W-1:0] win_d;

   assign at_min = (win_q == MIN_W);
   assign at_max = (win_q == MAX_W);

   generate
      if (ON_GRID) begin : g_grid
         // Every reachable value lies on the step grid: no clamp needed
         assign win_up = win_q + STEP_W;
         assign win_dn = win_q - STEP_W;
      end else begin : g_clamp
         logic [EXT_W-1:0] up_sum;
         assign up_sum = {1'b0, win_q} + STEP_X;
         assign win_up = (up_sum >= MAX_X) ? MAX_W : up_sum[WIN_W-1:0];
         assign win_dn = ({1'b0, win_q} >= FLOOR_X) ? (win_q - STEP_W) : MIN_W;
      end
   endgenerate

   always_comb begin
      unique case (act)
         ACT_SHRINK: win_d = win_dn;
         ACT_GROW:   win_d = win_up;
         default:    win_d = win_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= INIT_W;
      end else begin
         win_q <= win_d;
      end
   end

endmodule

// File: rtl/mode_escalator.sv
module mode_escalator
   import entadp_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  adapt_act_e        act,
   output logic [MODE_W-1:0] mode_q,
   output logic [SEL_W-1:0]  sel_q
);

   localparam logic [MODE_W-1:0] MODE_TOP = {MODE_W{1'b1}};

   logic [MODE_W-1:0] mode_d;

   always_comb begin
      mode_d = mode_q;
      if ((act == ACT_ESCALATE) && (mode_q != MODE_TOP)) begin
         mode_d = mode_q + MODE_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         sel_q  <= stage_decode(2'd0);
      end else begin
         mode_q <= mode_d;
         sel_q  <= stage_decode(mode_d[1:0]);
      end
   end

endmodule

// File: rtl/entropy_adapt_ctrl.sv
module entropy_adapt_ctrl
   import entadp_pkg::*;
#(
   parameter int WIN_W    = 6,
   parameter int WIN_INIT = 30,
   parameter int WIN_STEP = 5,
   parameter int WIN_MIN  = 20,
   parameter int WIN_MAX  = 60,
   parameter int MODE_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_stb,
   input  logic              ent_good,
   output logic [WIN_W-1:0]  win_len,
   output logic [MODE_W-1:0] osc_mode,
   output logic [SEL_W-1:0]  stage_sel
);

   generate
      if (MODE_W != 2) begin : g_bad_mode
         $error("MODE_W must be 2 for the ring-length decode");
      end
      if (WIN_STEP < 1) begin : g_bad_step
         $error("WIN_STEP must be at least 1");
      end
      if (!(WIN_MIN <= WIN_INIT && WIN_INIT <= WIN_MAX)) begin : g_bad_init
         $error("WIN_INIT must lie within WIN_MIN..WIN_MAX");
      end
      if (WIN_MIN >= WIN_MAX) begin : g_bad_bounds
         $error("WIN_MIN must be below WIN_MAX");
      end
      if (WIN_MAX >= (1 << WIN_W)) begin : g_bad_width
         $error("WIN_MAX does not fit in WIN_W bits");
      end
   endgenerate

   adapt_act_e act;
   logic       at_min;
   logic       at_max;

   adapt_decider u_decider (
      .sample_stb (sample_stb),
      .ent_good   (ent_good),
      .at_min     (at_min),
      .at_max     (at_max),
      .act        (act)
   );

   win_stepper #(
      .WIN_W    (WIN_W),
      .WIN_INIT (WIN_INIT),
      .WIN_STEP (WIN_STEP),
      .WIN_MIN  (WIN_MIN),
      .WIN_MAX  (WIN_MAX)
   ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (act),
      .win_q  (win_len),
      .at_min (at_min),
      .at_max (at_max)
   );

   mode_escalator #(
      .MODE_W (MODE_W)
   ) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .act    (act),
      .mode_q (osc_mode),
      .sel_q  (stage_sel)
   );

endmodule

// File: rtl/entropy_adapt_ctrl_chk.sv
module entropy_adapt_ctrl_chk #(
   parameter int WIN_W    = 6,
   parameter int WIN_STEP = 5,
   parameter int WIN_MIN  = 20,
   parameter int WIN_MAX  = 60,
   parameter int MODE_W   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_stb,
   input logic              ent_good,
   input logic [WIN_W-1:0]  win_len,
   input logic [MODE_W-1:0] osc_mode,
   input logic [2:0]        stage_sel
);

   // R3 R5: window always inside bounds
   a_r3_win_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(win_len) >= WIN_MIN) && (int'(win_len) <= WIN_MAX));

   // R2
   a_r2_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> ($stable(win_len) && $stable(osc_mode) && $stable(stage_sel)));

   // R3
   a_r3_shrink: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && ent_good && (int'(win_len) >= WIN_MIN + WIN_STEP))
      |=> (int'(win_len) == int'($past(win_len)) - WIN_STEP));

   // R4
   a_r4_floor_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && ent_good && (int'(win_len) == WIN_MIN))
      |=> ((int'(win_len) == WIN_MIN) && $stable(osc_mode)));

   // R5
   a_r5_grow: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && !ent_good && (int'(win_len) + WIN_STEP <= WIN_MAX))
      |=> ((int'(win_len) == int'($past(win_len)) + WIN_STEP) && $stable(osc_mode)));

   // R6
   a_r6_escalate: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && !ent_good && (int'(win_len) == WIN_MAX) && (osc_mode != '1))
      |=> ((int'(osc_mode) == int'($past(osc_mode)) + 1) && (int'(win_len) == WIN_MAX)));

   // R7
   a_r7_mode_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_mode == '1) |=> (osc_mode == '1));

   // R8
   a_r8_sel_decode: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(stage_sel) && (stage_sel[2] == (osc_mode == 2'd0)) &&
      (stage_sel[1] == (osc_mode == 2'd1)) && (stage_sel[0] == osc_mode[1]));

   // R10
   a_r10_mode_only_escalates: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && !ent_good && (int'(win_len) == WIN_MAX)) |=> $stable(osc_mode));

endmodule

bind entropy_adapt_ctrl entropy_adapt_ctrl_chk #(
   .WIN_W    (WIN_W),
   .WIN_STEP (WIN_STEP),
   .WIN_MIN  (WIN_MIN),
   .WIN_MAX  (WIN_MAX),
   .MODE_W   (MODE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_stb (sample_stb),
   .ent_good   (ent_good),
   .win_len    (win_len),
   .osc_mode   (osc_mode),
   .stage_sel  (stage_sel)
);

// File: tb/entropy_adapt_ctrl_tb.sv
`timescale 1ns/1ps
module entropy_adapt_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sample_stb = 1'b0;
   logic       ent_good = 1'b0;
   logic [5:0] win_len;
   logic [1:0] osc_mode;
   logic [2:0] stage_sel;
   logic [5:0] win_len2;
   logic [1:0] osc_mode2;
   logic [2:0] stage_sel2;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   entropy_adapt_ctrl dut_i (
      .clk (clk), .rst_n (rst_n), .sample_stb (sample_stb), .ent_good (ent_good),
      .win_len (win_len), .osc_mode (osc_mode), .stage_sel (stage_sel)
   );

   // Off-grid parameter set: exercises the clamping datapath
   entropy_adapt_ctrl #(
      .WIN_INIT (22), .WIN_STEP (7), .WIN_MIN (20), .WIN_MAX (40)
   ) dut2_i (
      .clk (clk), .rst_n (rst_n), .sample_stb (sample_stb), .ent_good (ent_good),
      .win_len (win_len2), .osc_mode (osc_mode2), .stage_sel (stage_sel2)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Strobe once; outputs are checked at the following falling edge
   task automatic strobe(input bit good);
      @(negedge clk);
      sample_stb = 1'b1;
      ent_good   = good;
      @(negedge clk);
      sample_stb = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 win", int'(win_len), 30);
      chk("R1 mode", int'(osc_mode), 0);
      chk("R1 sel", int'(stage_sel), 4);
      chk("R1 win dut2", int'(win_len2), 22);
   endtask

   task automatic t_hold();
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         ent_good = i[0];
      end
      @(negedge clk);
      chk("R2 win", int'(win_len), 30);
      chk("R2 mode", int'(osc_mode), 0);
   endtask

   task automatic t_latency();
      @(negedge clk);
      sample_stb = 1'b1;
      ent_good   = 1'b1;
      #5;
      chk("R9 before edge", int'(win_len), 30);
      @(negedge clk);
      sample_stb = 1'b0;
      chk("R9 after edge", int'(win_len), 25);
   endtask

   task automatic t_good_down();
      strobe(1'b1);
      chk("R3 shrink", int'(win_len), 20);
      strobe(1'b1);
      chk("R4 floor win", int'(win_len), 20);
      chk("R4 floor mode", int'(osc_mode), 0);
   endtask

   task automatic t_bad_up();
      for (int i = 1; i <= 8; i++) begin
         strobe(1'b0);
         chk("R5 grow", int'(win_len), 20 + 5 * i);
         chk("R5 mode kept", int'(osc_mode), 0);
      end
      strobe(1'b0);
      chk("R6 win at max", int'(win_len), 60);
      chk("R6 mode 1", int'(osc_mode), 1);
      chk("R8 sel mode1", int'(stage_sel), 2);
      strobe(1'b0);
      chk("R6 mode 2", int'(osc_mode), 2);
      chk("R8 sel mode2", int'(stage_sel), 1);
      strobe(1'b0);
      chk("R7 mode 3", int'(osc_mode), 3);
      chk("R8 sel mode3", int'(stage_sel), 1);
      strobe(1'b0);
      chk("R7 saturated", int'(osc_mode), 3);
      chk("R6 win stays", int'(win_len), 60);
      strobe(1'b1);
      chk("R10 win down", int'(win_len), 55);
      chk("R10 mode kept", int'(osc_mode), 3);
   endtask

   task automatic t_async_reset();
      @(negedge clk);
      #3;
      rst_n = 1'b0;
      #1;
      chk("R1 async win", int'(win_len), 30);
      chk("R1 async mode", int'(osc_mode), 0);
      chk("R1 async sel", int'(stage_sel), 4);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_clamp();
      do_reset();
      strobe(1'b1);
      chk("R3 clamp to min", int'(win_len2), 20);
      strobe(1'b0);
      chk("R5 dut2 grow", int'(win_len2), 27);
      strobe(1'b0);
      chk("R5 dut2 grow", int'(win_len2), 34);
      strobe(1'b0);
      chk("R5 clamp to max", int'(win_len2), 40);
      chk("R5 dut2 mode", int'(osc_mode2), 0);
      strobe(1'b0);
      chk("R6 dut2 mode", int'(osc_mode2), 1);
      chk("R6 dut2 win", int'(win_len2), 40);
   endtask

   initial begin
      t_reset();
      t_hold();
      t_latency();
      t_good_down();
      t_bad_up();
      t_async_reset();
      t_clamp();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule